// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block collects hardware statistics for a processor subsystem. It holds one free-running cycle counter and six programmable 32-bit event counters. Each event counter is bound to one line of an incoming event-pulse vector through an 8-bit event code. Software reaches every setting through a small word-addressed register bus. Writes take effect on the rising clock edge. Reads are combinational from the addressed register.

Counting is gated at two levels: a global enable, and a per-counter enable mask. The mask is changed through a pair of registers, where a written 1 sets a bit or clears a bit. Event counters are reached indirectly: a select register names one counter, and the event-type and event-count windows then act on that counter. Software can bump a counter directly, and the cycle counter can be slowed by a prescaler. When a counter wraps it leaves a sticky flag, and an interrupt line reports the flags that are unmasked.

Top module: `perf_mon`

## Requirements
- R1: Registers sit at these word addresses: 0 control, 1 count-enable set, 2 count-enable clear, 3 overflow flags, 4 software increment, 5 select, 6 cycle count, 7 event type, 8 event count, 9 interrupt-enable set, 10 interrupt-enable clear, 11 user access; other addresses read 0. After reset every counter, mask, flag and setting is 0, irq is 0, and control reads 0x3000: the counter count 6 sits in bits [15:11].
- R2: Control bit 0 is the global enable. While it is 0, no counter changes except through a bus write.
- R3: A control write with bit 1 set zeroes all six event counters. A control write with bit 2 set zeroes the cycle counter and its prescaler. Both bits read back as 0.
- R4: With control bit 3 set, the cycle counter advances once per 64 enabled clocks. With bit 3 clear, it advances on every enabled clock.
- R5: In both enable registers, bit 31 is the cycle counter and bits 0 to 5 are event counters 0 to 5. Writing 1 to set or clear changes the matching bit, and writing 0 leaves it alone. Both addresses read back the current mask, and unimplemented bits read 0.
- R6: An event code c from 1 to 16 counts one per clock in which ev_in[c-1] is high. Codes 0 and above 16 take no input events.
- R7: Select bits [4:0] name the counter used by the event-type window (bits [7:0]) and the event-count window. An index above 5 makes both windows read 0 and ignore writes.
- R8: Writing 1 to bit x of the software-increment register adds one to event counter x, but only if that counter is enabled, the global enable is set, and its event code is 0.
- R9: A counter that advances from 0xFFFFFFFF to 0 sets its overflow flag, using the same bit layout as R5. Flags stay set until a 1 is written to them at address 3.
- R10: irq is high exactly when a flag is set whose interrupt-enable bit is also set. The interrupt-enable mask uses the set/clear rules of R5.
- R11: The user-access register stores bit 0 and reads it back.
- R12: The cycle counter and the selected event counter can be loaded by a bus write. A load or reset wins over a count in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| ev_in | input | 16 | Hardware event pulses |
| irq | output | 1 | Overflow interrupt |
| |

## Verification
The bench builds the unit with its default values: six counters, a 16-line event vector and a 6-bit prescaler. These values keep the 64-clock divider window short enough to cross many times. Event codes are drawn from 0 to 19, so both the software-only code and the codes beyond the vector are exercised. Counters are loaded near 0xFFFFFFFF so that wraps, sticky flags and the interrupt are reached in a few cycles. Select indexes of 6 and 7 cover the dead windows.

// File: rtl/perf_mon.sv
module perf_mon #(
  parameter int NCNT   = 6,
  parameter int CW     = 32,
  parameter int NEV    = 16,
  parameter int DIVLOG = 6,
  parameter int AW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [NEV-1:0] ev_in,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTRL = AW'(0), A_ENS = AW'(1), A_ENC = AW'(2), A_OVF = AW'(3),
                            A_SWI = AW'(4), A_SEL = AW'(5), A_CYC = AW'(6), A_EVT = AW'(7),
                            A_CNT = AW'(8), A_IES = AW'(9), A_IEC = AW'(10), A_UAC = AW'(11);
  localparam logic [31:0] IMPL = {1'b1, {(31-NCNT){1'b0}}, {NCNT{1'b1}}};
  localparam int EW  = $clog2(NEV + 1);
  localparam int EPW = 2 ** EW;

  logic              en, div, uacc;
  logic [31:0]       cnten, inten, ovf;
  logic [4:0]        sel;
  logic [7:0]        evt [NCNT];
  logic [CW-1:0]     cnt [NCNT];
  logic [CW-1:0]     ccnt;
  logic [DIVLOG-1:0] pre;

  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire pclr    = wr_ctrl && bus_wdata[1];
  wire cclr    = wr_ctrl && bus_wdata[2];
  wire [31:0] sw    = (bus_wr && bus_addr == A_SWI) ? bus_wdata : 32'd0;
  wire [31:0] en_s  = (bus_wr && bus_addr == A_ENS) ? bus_wdata : 32'd0;
  wire [31:0] en_c  = (bus_wr && bus_addr == A_ENC) ? bus_wdata : 32'd0;
  wire [31:0] ie_s  = (bus_wr && bus_addr == A_IES) ? bus_wdata : 32'd0;
  wire [31:0] ie_c  = (bus_wr && bus_addr == A_IEC) ? bus_wdata : 32'd0;
  wire [31:0] ov_c  = (bus_wr && bus_addr == A_OVF) ? bus_wdata : 32'd0;
  wire        cyc_wr = bus_wr && bus_addr == A_CYC;
  wire        cyc_run  = en && cnten[31] && div;
  wire        cyc_tick = en && cnten[31] && (!div || &pre) && !cclr && !cyc_wr;
  wire [EPW-1:0] ev_pad = EPW'({ev_in, 1'b0});

  logic [NCNT-1:0] inc;
  logic [31:0]     wrap;
  logic [7:0]      sel_evt;
  logic [CW-1:0]   sel_cnt;
  logic            sel_ok;

  always_comb begin
    wrap = 32'd0;
    sel_evt = 8'd0;
    sel_cnt = '0;
    sel_ok = 1'b0;
    for (int i = 0; i < NCNT; i++) begin
      inc[i] = en && cnten[i] && !pclr && !(bus_wr && bus_addr == A_CNT && sel == 5'(i)) &&
               ((evt[i] == 8'd0) ? sw[i] : (evt[i] <= 8'(NEV) && ev_pad[evt[i][EW-1:0]]));
      wrap[i] = inc[i] && (&cnt[i]);
      if (sel == 5'(i)) begin
        sel_ok = 1'b1;
        sel_evt = evt[i];
        sel_cnt = cnt[i];
      end
    end
    wrap[31] = cyc_tick && (&ccnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; div <= 1'b0; uacc <= 1'b0; sel <= 5'd0;
      cnten <= 32'd0; inten <= 32'd0; ovf <= 32'd0;
      ccnt <= '0; pre <= '0;
      for (int i = 0; i < NCNT; i++) begin
        evt[i] <= 8'd0;
        cnt[i] <= '0;
      end
    end else begin
      if (wr_ctrl) begin
        en  <= bus_wdata[0];
        div <= bus_wdata[3];
      end
      if (bus_wr && bus_addr == A_SEL) sel  <= bus_wdata[4:0];
      if (bus_wr && bus_addr == A_UAC) uacc <= bus_wdata[0];
      cnten <= (cnten | en_s) & ~en_c & IMPL;
      inten <= (inten | ie_s) & ~ie_c & IMPL;
      ovf   <= (ovf & ~ov_c) | wrap;
      if (cclr) begin
        ccnt <= '0;
        pre  <= '0;
      end else begin
        if (cyc_wr) ccnt <= CW'(bus_wdata);
        else if (cyc_tick) ccnt <= ccnt + 1'b1;
        if (cyc_run) pre <= pre + 1'b1;
      end
      for (int i = 0; i < NCNT; i++) begin
        if (bus_wr && bus_addr == A_EVT && sel == 5'(i)) evt[i] <= bus_wdata[7:0];
        if (pclr) cnt[i] <= '0;
        else if (bus_wr && bus_addr == A_CNT && sel == 5'(i)) cnt[i] <= CW'(bus_wdata);
        else if (inc[i]) cnt[i] <= cnt[i] + 1'b1;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:       bus_rdata = {16'd0, 5'(NCNT), 7'd0, div, 2'b00, en};
      A_ENS, A_ENC: bus_rdata = cnten;
      A_OVF:        bus_rdata = ovf;
      A_SEL:        bus_rdata = {27'd0, sel};
      A_CYC:        bus_rdata = 32'(ccnt);
      A_EVT:        bus_rdata = sel_ok ? {24'd0, sel_evt} : 32'd0;
      A_CNT:        bus_rdata = sel_ok ? 32'(sel_cnt) : 32'd0;
      A_IES, A_IEC: bus_rdata = inten;
      A_UAC:        bus_rdata = {31'd0, uacc};
      default:      bus_rdata = 32'd0;
    endcase
  end

  assign irq = |(ovf & inten);

  // R2
  cyc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !bus_wr) |=> $stable(ccnt));
  for (genvar g = 0; g < NCNT; g++) begin : g_chk
    // R2
    ev_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !bus_wr) |=> $stable(cnt[g]));
  end
  // R4
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div && !bus_wr && !(&pre)) |=> $stable(ccnt));
  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_OVF) |=> ((ovf & $past(ovf)) == $past(ovf)));
  // R9
  cyc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf[31]) |-> ($past(ccnt) == '1 && ccnt == '0));
  // R5
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_ENS) |=> ((cnten & $past(bus_wdata & IMPL)) == $past(bus_wdata & IMPL)));
endmodule

// File: tb/perf_mon_tb.sv
module perf_mon_tb;
  localparam logic [3:0] CTRL = 0, ENS = 1, ENC = 2, OVF = 3, SWI = 4, SEL = 5, CYC = 6,
                         EVT = 7, CNT = 8, IES = 9, IEC = 10, UAC = 11;
  localparam logic [31:0] IMPL = 32'h8000_003F;

  logic clk = 0, rst_n = 0, wr = 0, irq;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [15:0] ev = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  perf_mon u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
                  .bus_rdata(rdata), .ev_in(ev), .irq(irq));

  logic m_en = 0, m_div = 0, m_uacc = 0;
  logic [31:0] m_cnten = 0, m_inten = 0, m_ovf = 0, m_ccnt = 0;
  logic [4:0] m_sel = 0;
  logic [5:0] m_pre = 0;
  logic [7:0] m_evt [6] = '{default: 0};
  logic [31:0] m_cnt [6] = '{default: 0};

  function automatic logic [31:0] m_read(logic [3:0] a);
    case (a)
      CTRL: return {16'd0, 5'd6, 7'd0, m_div, 2'b00, m_en};
      ENS, ENC: return m_cnten;
      OVF: return m_ovf;
      SEL: return {27'd0, m_sel};
      CYC: return m_ccnt;
      EVT: return (m_sel < 6) ? {24'd0, m_evt[m_sel]} : 32'd0;
      CNT: return (m_sel < 6) ? m_cnt[m_sel] : 32'd0;
      IES, IEC: return m_inten;
      UAC: return {31'd0, m_uacc};
      default: return 32'd0;
    endcase
  endfunction

  function automatic void m_step(logic [3:0] a, logic w, logic [31:0] d, logic [15:0] e);
    logic [31:0] sw = (w && a == SWI) ? d : 0;
    logic ctw = w && a == CTRL;
    logic [31:0] wrp = 0;
    logic tick = m_en && m_cnten[31] && (!m_div || m_pre == 6'd63);
    logic run = m_en && m_cnten[31] && m_div;
    for (int i = 0; i < 6; i++) begin
      logic hit = (m_evt[i] == 0) ? sw[i] : (m_evt[i] <= 16 && e[m_evt[i] - 1]);
      if (ctw && d[1]) m_cnt[i] = 0;
      else if (w && a == CNT && m_sel == 5'(i)) m_cnt[i] = d;
      else if (m_en && m_cnten[i] && hit) begin
        if (m_cnt[i] == 32'hFFFF_FFFF) wrp[i] = 1;
        m_cnt[i] = m_cnt[i] + 1;
      end
    end
    if (ctw && d[2]) begin
      m_ccnt = 0; m_pre = 0;
    end else begin
      if (w && a == CYC) m_ccnt = d;
      else if (tick) begin
        if (m_ccnt == 32'hFFFF_FFFF) wrp[31] = 1;
        m_ccnt = m_ccnt + 1;
      end
      if (run) m_pre = m_pre + 1;
    end
    m_ovf = (m_ovf & ~((w && a == OVF) ? d : 0)) | wrp;
    m_cnten = (m_cnten | ((w && a == ENS) ? d : 0)) & ~((w && a == ENC) ? d : 0) & IMPL;
    m_inten = (m_inten | ((w && a == IES) ? d : 0)) & ~((w && a == IEC) ? d : 0) & IMPL;
    if (w && a == EVT && m_sel < 6) m_evt[m_sel] = d[7:0];
    if (ctw) begin m_en = d[0]; m_div = d[3]; end
    if (w && a == SEL) m_sel = d[4:0];
    if (w && a == UAC) m_uacc = d[0];
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic [3:0] a, logic w, logic [31:0] d, logic [15:0] e, bit chk, string tag);
    @(negedge clk);
    addr = a; wr = w; wdata = d; ev = e;
    #1;
    if (chk) begin
      check(tag, rdata, m_read(a));
      check("R10 irq", {31'd0, irq}, {31'd0, |(m_ovf & m_inten)});
    end
    m_step(a, w, d, e);
  endtask

  task automatic wr_(logic [3:0] a, logic [31:0] d); cyc(a, 1, d, 0, 0, ""); endtask
  task automatic rd(logic [3:0] a, string tag); cyc(a, 0, 0, 0, 1, tag); endtask
  task automatic setc(int i, logic [7:0] code); wr_(SEL, i); wr_(EVT, code); endtask
  task automatic rdc(int i, string tag); wr_(SEL, i); rd(CNT, tag); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state and map
    rd(CTRL, "R1 ctrl"); rd(ENS, "R1 en"); rd(OVF, "R1 ovf"); rd(CYC, "R1 cyc");
    rd(4'd13, "R1 unmapped"); rd(CNT, "R1 cnt0");
    // R5 set/clear semantics
    wr_(ENS, 32'hFFFF_FFFF); rd(ENS, "R5 set readback");
    wr_(ENC, 32'h0000_0000); rd(ENC, "R5 clear zero no effect");
    wr_(ENC, 32'h0000_0012); rd(ENS, "R5 clear bits");
    wr_(ENS, 32'h0000_0000); rd(ENC, "R5 set zero no effect");
    wr_(ENS, 32'h0000_0012);
    // R6 event codes
    setc(0, 1); setc(1, 5); setc(2, 0); setc(3, 8'h20); setc(4, 16); setc(5, 3);
    // R2 gated off
    for (int k = 0; k < 5; k++) cyc(CTRL, 0, 0, 16'hFFFF, 0, "");
    rdc(0, "R2 gated cnt0"); rd(CYC, "R2 gated cyc");
    wr_(CTRL, 1);
    for (int k = 0; k < 8; k++) cyc(CTRL, 0, 0, 16'h8011 | 16'(k << 2), 0, "");
    for (int i = 0; i < 6; i++) rdc(i, "R6 event count");
    rd(CYC, "R4 undivided cyc");
    // R8 software increment
    wr_(SWI, 32'h3F); rdc(2, "R8 swinc code0"); rdc(0, "R8 swinc code1 ignored");
    wr_(ENC, 32'h4); wr_(SWI, 32'h4); rdc(2, "R8 swinc disabled");
    wr_(ENS, 32'h4);
    // R3 resets
    wr_(CTRL, 32'h3); rd(CTRL, "R3 self clear"); rdc(1, "R3 event reset"); rd(CYC, "R3 cyc kept");
    wr_(CTRL, 32'h5); rd(CYC, "R3 cyc reset");
    // R4 divider
    wr_(CTRL, 32'hD);
    for (int k = 0; k < 60; k++) cyc(CTRL, 0, 0, 0, 0, "");
    rd(CYC, "R4 div early");
    for (int k = 0; k < 70; k++) cyc(CTRL, 0, 0, 0, 0, "");
    rd(CYC, "R4 div after 64");
    wr_(CTRL, 1);
    // R7 select out of range
    wr_(SEL, 7); rd(EVT, "R7 evt idx7"); wr_(CNT, 32'h55); wr_(EVT, 8'h9); rd(CNT, "R7 cnt idx7");
    wr_(SEL, 6); rd(CNT, "R7 cnt idx6"); rd(SEL, "R7 sel readback");
    rdc(5, "R7 cnt5 untouched"); rd(EVT, "R7 evt5");
    // R12 / R9 / R10 overflow
    wr_(IES, 32'h8000_0001);
    wr_(SEL, 0); wr_(CNT, 32'hFFFF_FFFE); rd(CNT, "R12 load");
    cyc(CTRL, 0, 0, 16'h1, 0, ""); cyc(CTRL, 0, 0, 16'h1, 0, "");
    rd(OVF, "R9 wrap flag"); rd(CNT, "R9 wrapped");
    rd(OVF, "R9 sticky");
    wr_(CYC, 32'hFFFF_FFFD); rd(CYC, "R12 cyc load");
    for (int k = 0; k < 3; k++) rd(OVF, "R9 cyc wrap");
    wr_(IEC, 32'h8000_0001); rd(OVF, "R10 masked");
    wr_(OVF, 32'h8000_0000); rd(OVF, "R9 clear one");
    wr_(IES, 32'h1); rd(IES, "R10 inten");
    wr_(OVF, 32'hFFFF_FFFF); rd(OVF, "R9 clear all");
    // R11
    wr_(UAC, 32'hFFFF_FFFF); rd(UAC, "R11 set"); wr_(UAC, 32'h2); rd(UAC, "R11 clear");
    // random
    void'($urandom(32'd1234));
    for (int k = 0; k < 4000; k++) begin
      int r = $urandom % 10;
      logic [3:0] a = 4'($urandom % 13);
      logic [31:0] d = $urandom;
      logic [15:0] e = 16'($urandom);
      if (a == CTRL) d = {28'd0, 1'($urandom % 4 == 0), 1'($urandom % 8 == 0),
                          1'($urandom % 8 == 0), 1'($urandom % 6 != 0)};
      if (a == SEL) d = $urandom % 8;
      if (a == EVT) d = $urandom % 20;
      if ((a == CNT || a == CYC) && $urandom % 2) d = 32'hFFFF_FFF0 | 32'($urandom % 16);
      if (a == OVF || a == IEC || a == ENC) d = d & 32'($urandom);
      if (r < 5) cyc(a, 0, 0, e, 0, "");
      else if (r < 8) cyc(a, 1, d, e, 0, "");
      else cyc(a, 0, 0, e, 1, "R1-map random read");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule